// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a byte-addressed serial memory that sits on a two-wire bus as a slave. It oversamples the clock and data lines with the system clock. It recognises bus Start and Stop conditions and checks the control byte against a fixed four-bit device code and three select pins. It then receives a word pointer or serves read data. The data line is driven only through an open-drain enable: asserting `sda_oe` pulls the line low.

Write bytes are not stored here. Each accepted data byte is passed, together with its target location, to a separate page-write controller. A Stop that follows at least one data byte tells that controller to start its internal write cycle. While the controller reports busy, this block stays silent on the bus and acknowledges nothing, so a master can poll for completion. Reads use a synchronous RAM port with one cycle of read latency. The block keeps a 13-bit pointer that supports current-location, random and sequential reads.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a Start, and a rising data line while the clock line is high is a Stop. Received bits are taken on the clock rising edge, most significant bit first.
- R2: The first byte after a Start is accepted only when bits 7..4 equal 1010 and bits 3..1 equal `sel_pins`. Bit 0 selects the direction: 1 is read, 0 is write. On any other value the block leaves SDA released for the rest of the transfer, including later bytes and read slots, until the next Start.
- R3: Each accepted byte is acknowledged by holding `sda_oe` high through the whole high phase of the ninth clock. SDA is released after the ninth clock's falling edge.
- R4: While `wc_busy` is high when a byte completes, that byte is not acknowledged, and this includes a matching control byte.
- R5: After a write control byte, two pointer bytes follow, high byte first. The pointer is {high[4:0], low}, and bits 7..5 of the high byte have no effect.
- R6: Each write data byte after the pointer bytes gives one single-cycle `wr_valid` pulse carrying the pointer and the byte. The pointer then advances inside its 32-byte page: the low 5 bits wrap and the upper 8 bits are kept.
- R7: A Stop that ends a write transfer containing at least one data byte gives exactly one `wr_commit` pulse. A write transfer carrying only the pointer gives no `wr_valid` and no `wr_commit`.
- R8: A read control byte with no preceding pointer bytes returns the byte that follows the last location read.
- R9: A write control byte and two pointer bytes, followed by a repeated Start and a read control byte, return the byte at that pointer.
- R10: In a read, each master acknowledge makes the block send the byte at the next location. After a master not-acknowledge, SDA stays released.
- R11: The read pointer rolls from 0x1FFF to 0x0000. After each byte sent, the pointer addresses the following location.
- R12: A Start in the middle of a byte abandons that byte and begins control-byte matching again. Under reset, `sda_oe`, `mem_rd`, `wr_valid` and `wr_commit` are low.
- R13: Transmitted bits and acknowledges change only after a clock falling edge, and stay steady for the whole clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| sel_pins | input | 3 | Select value that control-byte bits 3..1 must equal |
| wc_busy | input | 1 | Page-write controller is running an internal write cycle |
| mem_addr | output | 13 | Read location for the array port |
| mem_rd | output | 1 | Read strobe; data is valid on mem_rdata one cycle later |
| mem_rdata | input | 8 | Read data from the array port |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 13 | Location of the byte on wr_valid |
| wr_data | output | 8 | Byte on wr_valid |
| wr_commit | output | 1 | One-cycle strobe: start the internal write cycle |

## Verification
Two functions can fall on the same bus event. On the falling edge that ends the byte read from 0x1FFF, the pointer rolls over while the master acknowledge is still pending, and the next fetch has to use the wrapped value. A sequential read that starts at 0x1FFE provokes this, and the check is that the third byte returned equals the value the bench last wrote to location 0. The second overlap is a busy flag that is still high while a matching control byte completes. Polling with a write control byte right after a committed Stop provokes it, and the check is that the first poll sees no acknowledge and that a later poll gets one.

// File: rtl/smem_pkg.sv
package smem_pkg;

    // Bus-level phase of the transfer engine
    typedef enum logic [2:0] {
        ST_IDLE,   // released, waiting for a Start
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // driving the acknowledge slot
        ST_TX,     // shifting out a read byte
        ST_MACK    // listening for the master acknowledge
    } st_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        RB_CTRL,
        RB_AHI,
        RB_ALO,
        RB_DATA
    } role_e;

endpackage

// File: rtl/line_sync_det.sv
module line_sync_det #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    typedef struct packed {
        logic [SYNC_N-1:0] scl_sy;
        logic [SYNC_N-1:0] sda_sy;
        logic              scl_p;
        logic              sda_p;
    } sy_t;

    sy_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.scl_sy = {s_q.scl_sy[SYNC_N-2:0], scl_in};
        s_d.sda_sy = {s_q.sda_sy[SYNC_N-2:0], sda_in};
        s_d.scl_p  = s_q.scl_sy[SYNC_N-1];
        s_d.sda_p  = s_q.sda_sy[SYNC_N-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s    = s_q.scl_sy[SYNC_N-1];
    assign sda_s    = s_q.sda_sy[SYNC_N-1];
    assign scl_rise = scl_s & ~s_q.scl_p;
    assign scl_fall = ~scl_s & s_q.scl_p;
    assign start_ev = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import smem_pkg::*;
#(
    parameter int          AW       = 13,
    parameter int          DW       = 8,
    parameter int          PW       = 5,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic [2:0]    sel_pins,
    input  logic          wc_busy,
    input  logic [DW-1:0] mem_rdata,
    output logic          sda_oe,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_commit
);

    localparam int            CNTW = $clog2(DW);
    localparam int            HIW  = AW - DW;
    localparam logic [CNTW-1:0] LAST = CNTW'(DW - 1);
    localparam logic [AW-1:0] PMAX = '1;

    typedef struct packed {
        st_e             st;
        role_e           role;
        logic [CNTW-1:0] cnt;
        logic [DW-2:0]   sh;
        logic [DW-1:0]   tx;
        logic [AW-1:0]   ptr;
        logic [HIW-1:0]  ahi;
        logic            drv;
        logic            rd_mode;
        logic            wd;
        logic            oe;
        logic            rd_req;
        logic            ld;
        logic            wv;
        logic [AW-1:0]   wa;
        logic [DW-1:0]   wdat;
        logic            commit;
    } regs_t;

    regs_t r_d, r_q;
    logic [DW-1:0] rx_byte;
    logic          ctrl_hit;

    assign rx_byte  = {r_q.sh, sda_s};
    assign ctrl_hit = (rx_byte[DW-1 -: 4] == DEV_CODE) && (rx_byte[DW-5 -: 3] == sel_pins);

    always_comb begin
        r_d        = r_q;
        r_d.rd_req = 1'b0;
        r_d.wv     = 1'b0;
        r_d.commit = 1'b0;
        r_d.ld     = r_q.rd_req;
        if (r_q.ld) r_d.tx = mem_rdata;

        if (stop_ev) begin
            r_d.st     = ST_IDLE;
            r_d.oe     = 1'b0;
            r_d.drv    = 1'b0;
            r_d.commit = r_q.wd;
            r_d.wd     = 1'b0;
        end else if (start_ev) begin
            r_d.st      = ST_RX;
            r_d.role    = RB_CTRL;
            r_d.cnt     = '0;
            r_d.oe      = 1'b0;
            r_d.drv     = 1'b0;
            r_d.rd_mode = 1'b0;
            r_d.wd      = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh  = rx_byte[DW-2:0];
                        r_d.cnt = r_q.cnt + CNTW'(1);
                        if (r_q.cnt == LAST) begin
                            r_d.cnt = '0;
                            r_d.st  = ST_ACK;
                            if (wc_busy) begin
                                r_d.st = ST_IDLE;
                            end else begin
                                unique case (r_q.role)
                                    RB_CTRL: begin
                                        if (ctrl_hit) begin
                                            r_d.rd_mode = rx_byte[0];
                                            r_d.rd_req  = rx_byte[0];
                                            r_d.role    = rx_byte[0] ? RB_CTRL : RB_AHI;
                                        end else begin
                                            r_d.st = ST_IDLE;
                                        end
                                    end
                                    RB_AHI: begin
                                        r_d.ahi  = rx_byte[HIW-1:0];
                                        r_d.role = RB_ALO;
                                    end
                                    RB_ALO: begin
                                        r_d.ptr  = {r_q.ahi, rx_byte};
                                        r_d.role = RB_DATA;
                                    end
                                    RB_DATA: begin
                                        r_d.wv   = 1'b1;
                                        r_d.wa   = r_q.ptr;
                                        r_d.wdat = rx_byte;
                                        r_d.wd   = 1'b1;
                                        r_d.ptr  = {r_q.ptr[AW-1:PW], r_q.ptr[PW-1:0] + PW'(1)};
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!r_q.drv) begin
                            r_d.drv = 1'b1;
                            r_d.oe  = 1'b1;
                        end else begin
                            r_d.drv = 1'b0;
                            r_d.cnt = '0;
                            if (r_q.rd_mode) begin
                                r_d.st = ST_TX;
                                r_d.oe = ~r_q.tx[DW-1];
                            end else begin
                                r_d.st = ST_RX;
                                r_d.oe = 1'b0;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST) begin
                            r_d.st  = ST_MACK;
                            r_d.oe  = 1'b0;
                            r_d.cnt = '0;
                            r_d.ptr = r_q.ptr + AW'(1);
                        end else begin
                            r_d.cnt = r_q.cnt + CNTW'(1);
                            r_d.tx  = {r_q.tx[DW-2:0], 1'b0};
                            r_d.oe  = ~r_q.tx[DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && !r_q.drv) begin
                        if (!sda_s) begin
                            r_d.drv    = 1'b1;
                            r_d.rd_req = 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else if (scl_fall && r_q.drv) begin
                        r_d.drv = 1'b0;
                        r_d.st  = ST_TX;
                        r_d.oe  = ~r_q.tx[DW-1];
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.oe;
    assign mem_addr  = r_q.ptr;
    assign mem_rd    = r_q.rd_req;
    assign wr_valid  = r_q.wv;
    assign wr_addr   = r_q.wa;
    assign wr_data   = r_q.wdat;
    assign wr_commit = r_q.commit;

    // R2: no drive while waiting for the next Start
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !r_q.oe);

    // R3: once the acknowledge slot is entered, the line is held low
    p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK && r_q.drv) |-> r_q.oe);

    // R7: a commit strobe only follows a Stop
    p_commit_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.commit |-> $past(stop_ev));

    // R10: the master acknowledge slot is left released
    p_mack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MACK) |-> !r_q.oe);

    // R11: pointer roll-over at the end of the last location
    p_ptr_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_TX && r_q.st == ST_MACK && $past(r_q.ptr) == PMAX)
        |-> (r_q.ptr == '0));

    // R12: a Start always restarts control matching
    p_start_ctrl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (r_q.st == ST_RX && r_q.role == RB_CTRL && r_q.cnt == '0));

    // R13: the data line output is steady through the clock high phase
    p_oe_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(r_q.oe));

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
    parameter int         ADDR_W   = 13,
    parameter int         DATA_W   = 8,
    parameter int         PAGE_W   = 5,
    parameter int         SYNC_N   = 2,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [2:0]        sel_pins,
    input  logic              wc_busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    line_sync_det #(
        .SYNC_N (SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    xfer_fsm #(
        .AW       (ADDR_W),
        .DW       (DATA_W),
        .PW       (PAGE_W),
        .DEV_CODE (DEV_CODE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sel_pins  (sel_pins),
        .wc_busy   (wc_busy),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int BUSY_CYC   = 600;
    localparam int WDOG       = 150000;
    localparam logic [2:0] SEL = 3'b101;
    // {address[12:0], junk high bits[2:0], data[7:0]}
    localparam logic [23:0] VEC [0:5] = '{
        {13'h0000, 3'b000, 8'h5A},
        {13'h1FFF, 3'b111, 8'hC3},
        {13'h0A55, 3'b101, 8'h00},
        {13'h1234, 3'b010, 8'hFF},
        {13'h0020, 3'b110, 8'h81},
        {13'h17E0, 3'b001, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, mem_rd, wr_valid, wr_commit, wc_busy;
    logic [12:0] mem_addr, wr_addr;
    logic [7:0]  mem_rdata = 8'h00, wr_data;
    wire sda_line = m_sda & ~sda_oe;

    serial_mem_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .sel_pins(SEL), .wc_busy(wc_busy), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit)
    );

    // Array and page-write controller models
    logic [7:0] wmem [int];
    logic [12:0] pa [32];
    logic [7:0]  pd [32];
    logic [12:0] la [256];
    logic [7:0]  ldat [256];
    int pn = 0, log_n = 0, commit_n = 0, busy_cnt = 0;
    assign wc_busy = (busy_cnt != 0);

    function automatic logic [7:0] init_val(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b011};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [12:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return init_val(a);
    endfunction

    function automatic logic [7:0] ctrl(input logic rw);
        return {4'b1010, SEL, rw};
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= exp_byte(mem_addr);
        if (wr_valid) begin
            pa[pn % 32] = wr_addr;
            pd[pn % 32] = wr_data;
            pn = pn + 1;
            la[log_n % 256]   = wr_addr;
            ldat[log_n % 256] = wr_data;
            log_n = log_n + 1;
        end
        if (wr_commit) begin
            for (int i = 0; i < pn && i < 32; i++) wmem[int'(pa[i])] = pd[i];
            pn = 0;
            commit_n = commit_n + 1;
            busy_cnt <= BUSY_CYC;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start;
        m_sda = 1'b1; qw; m_scl = 1'b1; qw; m_sda = 1'b0; qw; m_scl = 1'b0; qw;
    endtask

    task automatic m_stop;
        m_sda = 1'b0; qw; m_scl = 1'b1; qw; m_sda = 1'b1; qw; qw;
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw; m_scl = 1'b1; qw; qw; m_scl = 1'b0; qw;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw; m_scl = 1'b1; qw;
        a1 = ~sda_line; qw;
        a2 = ~sda_line; m_scl = 1'b0; qw;
        acked = a1 & a2;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d, output logic steady);
        logic s1, s2;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qw; m_scl = 1'b1; qw;
            s1 = sda_line; qw;
            s2 = sda_line;
            if (s1 !== s2) steady = 1'b0;
            d[i] = s1; m_scl = 1'b0; qw;
        end
        m_sda = mack ? 1'b0 : 1'b1; qw; m_scl = 1'b1; qw; qw; m_scl = 1'b0; qw;
        m_sda = 1'b1;
    endtask

    task automatic rnd_read(input logic [12:0] a, output logic [7:0] d);
        logic ak, st;
        m_start; send_byte(ctrl(1'b0), ak);
        send_byte({3'b000, a[12:8]}, ak); send_byte(a[7:0], ak);
        m_start; send_byte(ctrl(1'b1), ak);
        recv_byte(1'b0, d, st); m_stop;
    endtask

    logic [12:0] va;
    logic [2:0]  vj;
    logic [7:0]  vd, rd, b0, b1, b2;
    logic        ak, first_ak, stdy;
    int          l0, c0, npoll;

    initial begin
        repeat (5) @(negedge clk);
        check("R12 reset sda_oe", sda_oe, 0);
        check("R12 reset strobes", {mem_rd, wr_valid, wr_commit}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R12 after reset sda_oe", sda_oe, 0);

        // Table walk: byte write, poll while busy, random read back
        for (int k = 0; k < 6; k++) begin
            va = VEC[k][23:11]; vj = VEC[k][10:8]; vd = VEC[k][7:0];
            l0 = log_n; c0 = commit_n;
            m_start; send_byte(ctrl(1'b0), ak);
            check("R1 R3 write control acked", ak, 1);
            send_byte({vj, va[12:8]}, ak);
            send_byte(va[7:0], ak);
            send_byte(vd, ak);
            check("R3 data byte acked", ak, 1);
            m_stop;
            check("R6 one write strobe", log_n - l0, 1);
            check("R5 pointer ignores top bits", la[l0 % 256], va);
            check("R6 write data", ldat[l0 % 256], vd);
            check("R7 one commit", commit_n - c0, 1);
            npoll = 0; first_ak = 1'b1;
            do begin
                m_start; send_byte(ctrl(1'b0), ak);
                if (npoll == 0) first_ak = ak;
                npoll++;
            end while (!ak && npoll < 40);
            check("R4 no ack while busy", first_ak, 0);
            check("R4 ack after busy", ak, 1);
            send_byte({3'b000, va[12:8]}, ak); send_byte(va[7:0], ak);
            m_start; send_byte(ctrl(1'b1), ak);
            recv_byte(1'b0, rd, stdy); m_stop;
            check("R9 random read", rd, vd);
        end

        // R8: current-location read follows the last byte read
        m_start; send_byte(ctrl(1'b1), ak);
        recv_byte(1'b0, rd, stdy); m_stop;
        check("R8 current read", rd, exp_byte(13'h17E1));

        // R10 R11: sequential read across the top of the array
        m_start; send_byte(ctrl(1'b0), ak); send_byte(8'h1F, ak); send_byte(8'hFE, ak);
        m_start; send_byte(ctrl(1'b1), ak);
        recv_byte(1'b1, b0, stdy);
        check("R13 bits steady in high phase", stdy, 1);
        recv_byte(1'b1, b1, stdy);
        recv_byte(1'b0, b2, stdy);
        check("R10 first sequential", b0, exp_byte(13'h1FFE));
        check("R10 second sequential", b1, 8'hC3);
        check("R11 wrapped to zero", b2, 8'h5A);
        check("R10 released after nack", sda_line, 1);
        m_stop;
        m_start; send_byte(ctrl(1'b1), ak); recv_byte(1'b0, rd, stdy); m_stop;
        check("R11 pointer after wrap", rd, exp_byte(13'h0001));

        // R2: wrong device code and wrong select value
        m_start; send_byte({4'b1011, SEL, 1'b0}, ak);
        check("R2 wrong code no ack", ak, 0);
        send_byte(8'h00, ak);
        check("R2 silent until start", ak, 0);
        m_stop;
        m_start; send_byte({4'b1010, SEL ^ 3'b001, 1'b1}, ak);
        check("R2 wrong select no ack", ak, 0);
        recv_byte(1'b0, rd, stdy); m_stop;
        check("R2 no read data driven", rd, 8'hFF);

        // R6: page wrap of the write pointer
        l0 = log_n;
        m_start; send_byte(ctrl(1'b0), ak); send_byte(8'h00, ak); send_byte(8'h5E, ak);
        send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak); m_stop;
        check("R6 page addr 0", la[l0 % 256], 13'h005E);
        check("R6 page addr 1", la[(l0 + 1) % 256], 13'h005F);
        check("R6 page wrap addr", la[(l0 + 2) % 256], 13'h0040);
        while (wc_busy) @(negedge clk);
        rnd_read(13'h0040, rd);
        check("R6 wrapped byte stored", rd, 8'h33);
        rnd_read(13'h0060, rd);
        check("R6 next page untouched", rd, init_val(13'h0060));

        // R7: pointer-only write gives no strobes
        l0 = log_n; c0 = commit_n;
        m_start; send_byte(ctrl(1'b0), ak); send_byte(8'h0A, ak); send_byte(8'hBC, ak); m_stop;
        repeat (20) @(negedge clk);
        check("R7 no commit without data", commit_n - c0, 0);
        check("R7 no write strobe", log_n - l0, 0);

        // R12: Start in mid-byte restarts matching
        m_start;
        for (int i = 7; i >= 4; i--) send_bit(ctrl(1'b1)>>i);
        m_start; send_byte(ctrl(1'b1), ak);
        check("R12 control after abort acked", ak, 1);
        recv_byte(1'b0, rd, stdy); m_stop;
        check("R12 read after abort", rd, exp_byte(13'h0ABC));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(negedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R12: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule